// File: doc/BRIEF.md
# Special-Role Register File

This block is the operand store of a small 16-bit RISC core. It holds sixteen 16-bit entries. The lowest four have fixed jobs: entry 0 is the program counter, entry 1 the stack pointer, entry 2 the status word, and entry 3 a constant source. Entries 4 to 15 are ordinary working registers. The file has two combinational read ports and one synchronous write port. Besides the write port, two side paths change state. A flag path loads the low status bits. A step path advances the program counter by one instruction word.

Read port A carries the source operand. It takes a 2-bit source mode next to its address, so that entries 2 and 3 can stand in for small constants that the core would otherwise have to fetch. Read port B carries the destination operand and always returns stored contents. A write and a read of the same entry in the same cycle return the value being written. This lets a register-to-register operation read and write back in one clock.

The block has no state machine. Every register takes its next value from a fixed priority of write, side path and hold.

Top module: `sprf_top`

## Requirements
- R1: While reset is low every entry becomes zero, so after release both read ports return 0 for every address and `pc_q`, `sr_q` are 0.
- R2: A write with `wr_en` high to an entry 4..15 stores `wr_data` at the rising edge, and it is visible on both read ports afterwards.
- R3: Port A reading entry 3 returns 0, 1, 2 or 0xFFFF for source mode 00, 01, 10 or 11. Port B reading entry 3 returns 0.
- R4: Writes to entry 3 have no effect: its reads keep returning the constants of R3, and no other entry changes.
- R5: Port A reading entry 2 returns the stored status word for mode 00, 0 for mode 01, 4 for mode 10 and 8 for mode 11.
- R6: A write to entry 0 or entry 1 stores `wr_data` with bit 0 cleared.
- R7: When a read address equals the write address (not 3) while `wr_en` is high, the read returns the value being written, with bit 0 cleared for entries 0 and 1. On port A this holds unless R5 selects a constant.
- R8: When `pc_inc` is high and no write targets entry 0, the program counter grows by 2 at the edge, wrapping at 16 bits. A write to entry 0 in the same cycle takes priority.
- R9: When `flag_we` is high, bits 3:0 of the status word take `flag_data` and bits 15:4 are kept. A write to entry 2 in the same cycle takes priority over the flag path.
- R10: For entries 0, 1 and 4..15, port A returns the stored value whatever the source mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears all entries |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| flag_we | input | 1 | Status flag load strobe |
| flag_data | input | 4 | New values of status bits 3:0 |
| pc_inc | input | 1 | Advance program counter by 2 |
| ra_addr | input | 4 | Source read address |
| ra_mode | input | 2 | Source mode (00, 01, 10, 11) |
| ra_data | output | 16 | Source read data |
| rb_addr | input | 4 | Destination read address |
| rb_data | output | 16 | Destination read data |
| pc_q | output | 16 | Current program counter |
| sr_q | output | 16 | Current status word |

## Verification
The bench aims at the places where the fixed-role entries behave differently from working registers.

- It writes odd values to entries 0 and 1. A file that stored bit 0 would show a misaligned counter or stack pointer.
- It writes to entry 3 and reads the constants back. A design that stored the write would return that data where a constant belongs.
- It collides the flag path and a status write in the same cycle, and does the same with the step path and a counter write. A wrong priority shows up as stale flags or a counter that moved by 2 instead of loading.
- Random traffic checks same-cycle bypass against a model. A missing bypass returns the old value for one cycle.

// File: rtl/sprf_pkg.sv
package sprf_pkg;

    typedef enum logic [1:0] {
        SRC_DIRECT  = 2'b00,
        SRC_OFFSET  = 2'b01,
        SRC_POINTER = 2'b10,
        SRC_POSTINC = 2'b11
    } src_mode_e;

    localparam int unsigned IDX_PC  = 0;
    localparam int unsigned IDX_SP  = 1;
    localparam int unsigned IDX_SR  = 2;
    localparam int unsigned IDX_CG2 = 3;

    localparam int unsigned SR_CONST_POINTER = 4;
    localparam int unsigned SR_CONST_POSTINC = 8;

endpackage

// File: rtl/rf_const_gen.sv
module rf_const_gen
    import sprf_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 4
) (
    input  logic [AW-1:0] addr,
    input  src_mode_e     mode,
    output logic          hit,
    output logic [DW-1:0] value
);

    always_comb begin
        hit   = 1'b0;
        value = '0;
        if (addr == AW'(IDX_CG2)) begin
            hit = 1'b1;
            unique case (mode)
                SRC_DIRECT:  value = DW'(0);
                SRC_OFFSET:  value = DW'(1);
                SRC_POINTER: value = DW'(2);
                SRC_POSTINC: value = '1;
                default:     value = '0;
            endcase
        end else if (addr == AW'(IDX_SR) && mode != SRC_DIRECT) begin
            hit = 1'b1;
            unique case (mode)
                SRC_OFFSET:  value = DW'(0);
                SRC_POINTER: value = DW'(SR_CONST_POINTER);
                SRC_POSTINC: value = DW'(SR_CONST_POSTINC);
                default:     value = '0;
            endcase
        end
    end

endmodule

// File: rtl/rf_store.sv
module rf_store
    import sprf_pkg::*;
#(
    parameter int unsigned DW      = 16,
    parameter int unsigned NREG    = 16,
    parameter int unsigned FLAG_W  = 4,
    parameter int unsigned PC_STEP = 2,
    localparam int unsigned AW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_word,
    input  logic          flag_we,
    input  logic [FLAG_W-1:0] flag_data,
    input  logic          pc_inc,
    output logic [DW-1:0] q [NREG]
);

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic sel;
        assign sel = wr_hit && (wr_addr == AW'(g));

        if (g == IDX_CG2) begin : g_const
            assign q[g] = '0;
        end else if (g == IDX_PC) begin : g_pc
            logic [DW-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      r <= '0;
                else if (sel)    r <= wr_word;
                else if (pc_inc) r <= r + DW'(PC_STEP);
            end
            assign q[g] = r;
        end else if (g == IDX_SR) begin : g_sr
            logic [DW-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       r <= '0;
                else if (sel)     r <= wr_word;
                else if (flag_we) r <= {r[DW-1:FLAG_W], flag_data};
            end
            assign q[g] = r;
        end else begin : g_plain
            logic [DW-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   r <= '0;
                else if (sel) r <= wr_word;
            end
            assign q[g] = r;
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import sprf_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned NREG   = 16,
    parameter bit          HAS_CG = 1'b1,
    localparam int unsigned AW    = $clog2(NREG)
) (
    input  logic [AW-1:0] addr,
    input  src_mode_e     mode,
    input  logic [DW-1:0] regs [NREG],
    input  logic          byp_en,
    input  logic [AW-1:0] byp_addr,
    input  logic [DW-1:0] byp_data,
    output logic [DW-1:0] data
);

    logic [DW-1:0] stored;
    logic          byp_hit;

    assign byp_hit = byp_en && (byp_addr == addr);
    assign stored  = byp_hit ? byp_data : regs[addr];

    if (HAS_CG) begin : g_cg
        logic          cg_hit;
        logic [DW-1:0] cg_val;
        rf_const_gen #(.DW(DW), .AW(AW)) u_cg (
            .addr  (addr),
            .mode  (mode),
            .hit   (cg_hit),
            .value (cg_val)
        );
        assign data = cg_hit ? cg_val : stored;
    end else begin : g_plain
        logic unused_mode;
        assign unused_mode = ^mode;
        assign data = stored;
    end

endmodule

// File: rtl/sprf_top.sv
module sprf_top
    import sprf_pkg::*;
#(
    parameter int unsigned DW      = 16,
    parameter int unsigned NREG    = 16,
    parameter int unsigned FLAG_W  = 4,
    parameter int unsigned PC_STEP = 2,
    localparam int unsigned AW     = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_data,
    input  logic              pc_inc,
    input  logic [AW-1:0]     ra_addr,
    input  src_mode_e         ra_mode,
    output logic [DW-1:0]     ra_data,
    input  logic [AW-1:0]     rb_addr,
    output logic [DW-1:0]     rb_data,
    output logic [DW-1:0]     pc_q,
    output logic [DW-1:0]     sr_q
);

    logic [DW-1:0] regs [NREG];
    logic          wr_hit;
    logic          aligned_dst;
    logic [DW-1:0] wr_word;

    assign wr_hit      = wr_en && (wr_addr != AW'(IDX_CG2));
    assign aligned_dst = (wr_addr == AW'(IDX_PC)) || (wr_addr == AW'(IDX_SP));
    assign wr_word     = aligned_dst ? {wr_data[DW-1:1], 1'b0} : wr_data;

    rf_store #(.DW(DW), .NREG(NREG), .FLAG_W(FLAG_W), .PC_STEP(PC_STEP)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wr_addr   (wr_addr),
        .wr_word   (wr_word),
        .flag_we   (flag_we),
        .flag_data (flag_data),
        .pc_inc    (pc_inc),
        .q         (regs)
    );

    rf_read_port #(.DW(DW), .NREG(NREG), .HAS_CG(1'b1)) u_port_a (
        .addr     (ra_addr),
        .mode     (ra_mode),
        .regs     (regs),
        .byp_en   (wr_hit),
        .byp_addr (wr_addr),
        .byp_data (wr_word),
        .data     (ra_data)
    );

    rf_read_port #(.DW(DW), .NREG(NREG), .HAS_CG(1'b0)) u_port_b (
        .addr     (rb_addr),
        .mode     (SRC_DIRECT),
        .regs     (regs),
        .byp_en   (wr_hit),
        .byp_addr (wr_addr),
        .byp_data (wr_word),
        .data     (rb_data)
    );

    assign pc_q = regs[IDX_PC];
    assign sr_q = regs[IDX_SR];

endmodule

// File: rtl/sprf_chk.sv
module sprf_chk
    import sprf_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned FLAG_W = 4,
    parameter int unsigned AW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic              flag_we,
    input logic [FLAG_W-1:0] flag_data,
    input logic              pc_inc,
    input logic [AW-1:0]     ra_addr,
    input src_mode_e         ra_mode,
    input logic [DW-1:0]     ra_data,
    input logic [DW-1:0]     pc_q,
    input logic [DW-1:0]     sr_q
);

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[0] == 1'b0); // R6

    AST_CG2_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == AW'(IDX_CG2) && ra_mode == SRC_POSTINC) |-> ra_data == '1); // R3

    AST_SR_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == AW'(IDX_SR) && ra_mode == SRC_POINTER) |-> ra_data == DW'(4)); // R5

    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ra_addr && ra_addr > AW'(IDX_CG2)) |-> ra_data == wr_data); // R7

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !(wr_en && wr_addr == AW'(IDX_PC))) |=> pc_q == $past(pc_q) + DW'(2)); // R8

    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !(wr_en && wr_addr == AW'(IDX_SR)))
            |=> (sr_q[FLAG_W-1:0] == $past(flag_data)
                 && sr_q[DW-1:FLAG_W] == $past(sr_q[DW-1:FLAG_W]))); // R9

endmodule

bind sprf_top sprf_chk #(.DW(DW), .FLAG_W(FLAG_W), .AW(AW)) u_chk (.*);

// File: tb/tb_sprf_top.sv
module tb_sprf_top;
    import sprf_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        flag_we = 1'b0;
    logic [3:0]  flag_data = '0;
    logic        pc_inc = 1'b0;
    logic [3:0]  ra_addr = '0;
    src_mode_e   ra_mode = SRC_DIRECT;
    logic [15:0] ra_data;
    logic [3:0]  rb_addr = '0;
    logic [15:0] rb_data;
    logic [15:0] pc_q;
    logic [15:0] sr_q;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] mdl [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    sprf_top dut (.*);

    function automatic logic [15:0] wr_val(input logic [3:0] a, input logic [15:0] d);
        return (a < 2) ? {d[15:1], 1'b0} : d;
    endfunction

    function automatic logic [15:0] exp_read(input logic [3:0] a, input logic [1:0] m, input bit port_a);
        if (port_a && a == 3) begin
            case (m)
                2'd0: return 16'd0;
                2'd1: return 16'd1;
                2'd2: return 16'd2;
                default: return 16'hFFFF;
            endcase
        end
        if (port_a && a == 2 && m != 0)
            return (m == 1) ? 16'd0 : (m == 2) ? 16'd4 : 16'd8;
        if (wr_en && wr_addr == a && a != 3) return wr_val(a, wr_data);
        return mdl[a];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_reads();
        logic [15:0] ea, eb;
        string ta;
        ea = exp_read(ra_addr, ra_mode, 1'b1);
        eb = exp_read(rb_addr, 2'd0, 1'b0);
        if (ra_addr == 3) ta = "R3";
        else if (ra_addr == 2 && ra_mode != SRC_DIRECT) ta = "R5";
        else if (wr_en && wr_addr == ra_addr) ta = "R7";
        else if (ra_addr < 2) ta = "R10";
        else ta = "R2";
        check(ra_data === ea, ta, ra_data, ea);
        check(rb_data === eb, (wr_en && wr_addr == rb_addr && rb_addr != 3) ? "R7 portB" : "R2 portB", rb_data, eb);
        check(pc_q === mdl[0], "R8 pc", pc_q, mdl[0]);
        check(sr_q === mdl[2], "R9 sr", sr_q, mdl[2]);
    endtask

    task automatic update_model();
        logic [15:0] nx [16];
        for (int i = 0; i < 16; i++) nx[i] = mdl[i];
        if (wr_en && wr_addr != 3) nx[wr_addr] = wr_val(wr_addr, wr_data);
        else nx[3] = 16'd0;
        if (pc_inc && !(wr_en && wr_addr == 0)) nx[0] = mdl[0] + 16'd2;
        if (flag_we && !(wr_en && wr_addr == 2)) nx[2] = {mdl[2][15:4], flag_data};
        for (int i = 0; i < 16; i++) mdl[i] = nx[i];
    endtask

    task automatic step();
        #1;
        check_reads();
        @(posedge clk);
        update_model();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; flag_we = 0; pc_inc = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) mdl[i] = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every entry zero after reset
        for (int i = 0; i < 16; i++) begin
            ra_addr = 4'(i); rb_addr = 4'(i); ra_mode = SRC_DIRECT;
            #1;
            if (i != 3) check(ra_data === 16'd0, "R1 portA", ra_data, 16'd0);
            check(rb_data === 16'd0, "R1 portB", rb_data, 16'd0);
        end
        check(pc_q === 16'd0 && sr_q === 16'd0, "R1 pc/sr", pc_q, 16'd0);
        @(negedge clk);

        // R6: odd values into PC and SP
        wr_en = 1; wr_addr = 0; wr_data = 16'h1235; ra_addr = 0; rb_addr = 1; step();
        wr_addr = 1; wr_data = 16'hABCF; ra_addr = 1; step();
        idle(); ra_addr = 0; rb_addr = 1; #1;
        check(ra_data === 16'h1234, "R6 pc", ra_data, 16'h1234);
        check(rb_data === 16'hABCE, "R6 sp", rb_data, 16'hABCE);
        @(negedge clk);

        // R4 and R3: write to constant entry, read all modes
        wr_en = 1; wr_addr = 3; wr_data = 16'h5A5A; rb_addr = 3; ra_addr = 3; step();
        idle();
        for (int m = 0; m < 4; m++) begin
            ra_mode = src_mode_e'(m); ra_addr = 3; #1;
            check(ra_data === exp_read(4'd3, 2'(m), 1'b1), "R4 cg2 after write", ra_data, exp_read(4'd3, 2'(m), 1'b1));
            check(rb_data === 16'd0, "R3 portB cg2", rb_data, 16'd0);
            @(negedge clk);
        end

        // R8: wrap and priority of write over step
        wr_en = 1; wr_addr = 0; wr_data = 16'hFFFE; step();
        wr_en = 0; pc_inc = 1; ra_addr = 0; ra_mode = SRC_DIRECT; step();
        idle(); #1;
        check(pc_q === 16'h0000, "R8 wrap", pc_q, 16'h0000);
        wr_en = 1; wr_addr = 0; wr_data = 16'h0100; pc_inc = 1; step();
        idle(); #1;
        check(pc_q === 16'h0100, "R8 write wins", pc_q, 16'h0100);

        // R9: flag load keeps upper bits; write to SR wins
        wr_en = 1; wr_addr = 2; wr_data = 16'hC3A0; step();
        wr_en = 0; flag_we = 1; flag_data = 4'h5; step();
        idle(); #1;
        check(sr_q === 16'hC3A5, "R9 flags", sr_q, 16'hC3A5);
        wr_en = 1; wr_addr = 2; wr_data = 16'h0F00; flag_we = 1; flag_data = 4'hF; step();
        idle(); ra_addr = 2;
        for (int m = 0; m < 4; m++) begin
            ra_mode = src_mode_e'(m); #1;
            check(ra_data === exp_read(4'd2, 2'(m), 1'b1), "R5 sr modes", ra_data, exp_read(4'd2, 2'(m), 1'b1));
            @(negedge clk);
        end
        check(sr_q === 16'h0F00, "R9 write wins", sr_q, 16'h0F00);

        // R7: directed bypass on a working register
        wr_en = 1; wr_addr = 9; wr_data = 16'hBEEF; ra_addr = 9; rb_addr = 9; ra_mode = SRC_POSTINC; step();

        // Random traffic: R2, R7, R10 and side paths
        for (int k = 0; k < 3000; k++) begin
            wr_en     = ($urandom % 4) != 0;
            wr_addr   = 4'($urandom);
            wr_data   = 16'($urandom);
            flag_we   = ($urandom % 3) == 0;
            flag_data = 4'($urandom);
            pc_inc    = ($urandom % 2) == 0;
            ra_addr   = (($urandom % 3) == 0) ? wr_addr : 4'($urandom);
            rb_addr   = (($urandom % 3) == 0) ? wr_addr : 4'($urandom);
            ra_mode   = src_mode_e'($urandom % 4);
            step();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule